// File: doc/BRIEF.md
# Bit-Band Alias Remapping Unit

This unit sits on the path from one bus master to one memory or peripheral slave port. It watches every request for addresses that land in one of two alias windows. Each 32-bit word of an alias window stands for a single bit of a smaller, bit-addressable window below it. A load from an alias word returns that one bit in bit 0 of the read data, with every other bit zero. A store to an alias word sets or clears that bit alone, using a locked read followed by a locked write of the underlying location.

Requests outside the alias windows, including direct requests to the bit-addressable windows, go to the slave untouched. Instruction fetches from the SRAM alias are not remapped. Instruction fetches from the peripheral alias, and exclusive accesses to either alias, get an error response and never reach the slave.

Bus convention, on both sides: a transfer completes at the rising clock edge where request and ready are both high, and the response (read data, error) is valid in that same cycle. The master holds its request stable until it sees ready. Data sits on byte lanes by address (little-endian: byte address bits [1:0] pick the lane). Size codes are 0 for byte, 1 for halfword and 2 for word.

Top module: `bb_alias_unit`

## Requirements
- R1: A request outside both alias windows, including a direct request to a bit-addressable window, reaches the slave with the same address, size, direction and write data, with the lock flag low. Its read data returns to the master unchanged.
- R2: The SRAM alias 0x22000000–0x23FFFFFF maps onto the window at 0x20000000. The peripheral alias 0x42000000–0x43FFFFFF maps onto the window at 0x40000000. Addresses just outside an alias, such as 0x21FFFFFC and 0x24000000, are not remapped.
- R3: For an alias offset `off`, the slave address is the window base plus `off >> 5`, aligned down to the request size: clear bit 0 for a halfword, bits [1:0] for a word. The slave size equals the master size.
- R4: An alias read returns in bit 0 the data bit at bus position `off[6:2]`, which is bit `off[4:2]` of byte lane `(off>>5)[1:0]`. Read-data bits 31:1 are zero.
- R5: An alias write makes exactly two slave transfers, both with the lock flag high: a read and then a write to the same address and size. The written data is the read data with the selected bit replaced by bit 0 of the master write data. All other bits keep their value.
- R6: While the locked read is outstanding, master ready stays low. No other slave transfer occurs between the locked read and its write. The master transfer completes in the cycle the locked write is accepted.
- R7: An instruction fetch from the SRAM alias passes through like R1, to the alias address itself.
- R8: An instruction fetch from the peripheral alias completes at once with the error flag high and zero read data, and makes no slave request.
- R9: An exclusive request to either alias completes at once with the error flag high and makes no slave request. An exclusive request outside the aliases passes through.
- R10: After reset with no master request, the slave request and lock flag are low and the error flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| m_req | input | 1 | Master request valid |
| m_addr | input | 32 | Master byte address |
| m_we | input | 1 | Master write (1) or read (0) |
| m_size | input | 2 | Master size: 0 byte, 1 halfword, 2 word |
| m_wdata | input | 32 | Master write data, lane-positioned |
| m_fetch | input | 1 | Request is an instruction fetch |
| m_excl | input | 1 | Request is exclusive |
| m_ready | output | 1 | Master transfer completes this cycle |
| m_rdata | output | 32 | Read data to master |
| m_err | output | 1 | Error response, valid with m_ready |
| s_req | output | 1 | Slave request valid |
| s_addr | output | 32 | Slave byte address |
| s_we | output | 1 | Slave write (1) or read (0) |
| s_size | output | 2 | Slave size |
| s_wdata | output | 32 | Slave write data |
| s_lock | output | 1 | Slave request is part of a locked read-modify-write |
| s_ready | input | 1 | Slave accepts the request this cycle |
| s_rdata | input | 32 | Slave read data, valid with s_ready |

## Verification
The bench builds the unit with its default parameters: a 32-bit bus, two 1 MB windows at 0x20000000 and 0x40000000, a 32 MB alias gap, and fetch faulting only on the second window. These values reach the last alias word (bit 31 of the window's top word), the edges of each alias, and lane selection for every size. The slave model switches between ready always high, one stall in three, and ready only one cycle in four. This keeps the locked read waiting across several cycles, so the hold-off and the no-intervening-transfer rules are exercised under real back-pressure.

// File: rtl/bb_alias_pkg.sv
package bb_alias_pkg;

   typedef enum logic [1:0] {
      K_PASS     = 2'd0,
      K_ALIAS_RD = 2'd1,
      K_ALIAS_WR = 2'd2,
      K_FAULT    = 2'd3
   } route_e;

   // low address bits cleared to align a transfer of the given size
   function automatic logic [2:0] size_low_mask(input logic [1:0] sz);
      case (sz)
         2'd0:    return 3'b000;
         2'd1:    return 3'b001;
         2'd2:    return 3'b011;
         default: return 3'b111;
      endcase
   endfunction

endpackage

// File: rtl/bb_window_decode.sv
module bb_window_decode #(
   parameter int                              ADDR_W      = 32,
   parameter int                              DW          = 32,
   parameter int                              NWIN        = 2,
   parameter int                              WIN_LOG2    = 20,
   parameter logic [ADDR_W-1:0]               ALIAS_GAP   = 32'h0200_0000,
   parameter logic [NWIN-1:0][ADDR_W-1:0]     WIN_BASE    = {32'h4000_0000, 32'h2000_0000},
   parameter logic [NWIN-1:0]                 FETCH_FAULT = 2'b10,
   parameter int                              POS_W       = $clog2(DW)
) (
   input  logic [ADDR_W-1:2] addr_w,
   output logic              hit,
   output logic              fetch_fault,
   output logic [ADDR_W-1:0] tgt_byte,
   output logic [POS_W-1:0]  bitpos
);
   localparam int ALIAS_LOG2 = WIN_LOG2 + 5;
   localparam int LANE_LOG2  = $clog2(DW / 8);

   logic [NWIN-1:0]              hit_w;
   logic [NWIN-1:0]              ff_w;
   logic [NWIN-1:0][ADDR_W-1:0]  byte_w;

   for (genvar w = 0; w < NWIN; w++) begin : g_win
      localparam logic [ADDR_W-1:0] ABASE = WIN_BASE[w] + ALIAS_GAP;
      assign hit_w[w]  = (addr_w[ADDR_W-1:ALIAS_LOG2] == ABASE[ADDR_W-1:ALIAS_LOG2]);
      assign byte_w[w] = WIN_BASE[w] | ADDR_W'(addr_w[ALIAS_LOG2-1:5]);
      if (FETCH_FAULT[w]) begin : g_fault
         assign ff_w[w] = 1'b1;
      end else begin : g_pass
         assign ff_w[w] = 1'b0;
      end
   end

   always_comb begin
      hit         = 1'b0;
      fetch_fault = 1'b0;
      tgt_byte    = '0;
      for (int w = 0; w < NWIN; w++) begin
         if (hit_w[w]) begin
            hit         = 1'b1;
            fetch_fault = ff_w[w];
            tgt_byte    = byte_w[w];
         end
      end
   end

   // bus bit position: byte lane of the target byte, then bit within the byte
   assign bitpos = {tgt_byte[LANE_LOG2-1:0], addr_w[4:2]};

   // R2: alias windows never overlap, so at most one can claim an address
   always_comb begin
      p_alias_onehot_r2: assert ($onehot0(hit_w)) else $error("alias windows overlap");
   end

endmodule

// File: rtl/bb_rmw_seq.sv
module bb_rmw_seq #(
   parameter int DW    = 32,
   parameter int POS_W = $clog2(DW)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             s_ready,
   input  logic [DW-1:0]    s_rdata,
   input  logic [POS_W-1:0] bitpos,
   input  logic             new_bit,
   output logic             wr_phase,
   output logic [DW-1:0]    merged
);
   logic [DW-1:0] held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_phase <= 1'b0;
         held     <= '0;
      end else if (!wr_phase) begin
         if (start && s_ready) begin
            wr_phase <= 1'b1;
            held     <= s_rdata;
         end
      end else if (s_ready) begin
         wr_phase <= 1'b0;
      end
   end

   always_comb begin
      merged         = held;
      merged[bitpos] = new_bit;
   end

   // R5: the write phase is only ever entered on behalf of an alias write
   p_phase_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_phase |-> start);

endmodule

// File: rtl/bb_alias_unit.sv
module bb_alias_unit #(
   parameter int                              ADDR_W      = 32,
   parameter int                              DW          = 32,
   parameter int                              NWIN        = 2,
   parameter int                              WIN_LOG2    = 20,
   parameter logic [ADDR_W-1:0]               ALIAS_GAP   = 32'h0200_0000,
   parameter logic [NWIN-1:0][ADDR_W-1:0]     WIN_BASE    = {32'h4000_0000, 32'h2000_0000},
   parameter logic [NWIN-1:0]                 FETCH_FAULT = 2'b10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              m_req,
   input  logic [ADDR_W-1:0] m_addr,
   input  logic              m_we,
   input  logic [1:0]        m_size,
   input  logic [DW-1:0]     m_wdata,
   input  logic              m_fetch,
   input  logic              m_excl,
   output logic              m_ready,
   output logic [DW-1:0]     m_rdata,
   output logic              m_err,
   output logic              s_req,
   output logic [ADDR_W-1:0] s_addr,
   output logic              s_we,
   output logic [1:0]        s_size,
   output logic [DW-1:0]     s_wdata,
   output logic              s_lock,
   input  logic              s_ready,
   input  logic [DW-1:0]     s_rdata
);
   import bb_alias_pkg::*;

   localparam int POS_W      = $clog2(DW);
   localparam int ALIAS_LOG2 = WIN_LOG2 + 5;

   initial begin : elab_chk
      assert (DW == 16 || DW == 32 || DW == 64) else $error("DW must be 16, 32 or 64");
      assert (ALIAS_LOG2 < ADDR_W) else $error("alias window does not fit the address");
      assert (ALIAS_GAP[ALIAS_LOG2-1:0] == '0) else $error("ALIAS_GAP not alias-aligned");
      for (int w = 0; w < NWIN; w++) begin
         assert (WIN_BASE[w][ALIAS_LOG2-1:0] == '0) else $error("window base misaligned");
      end
   end

   logic              hit;
   logic              fetch_fault;
   logic [ADDR_W-1:0] tgt_byte;
   logic [ADDR_W-1:0] tgt_addr;
   logic [POS_W-1:0]  bitpos;
   logic              wr_phase;
   logic [DW-1:0]     merged;
   route_e            route;

   bb_window_decode #(
      .ADDR_W(ADDR_W), .DW(DW), .NWIN(NWIN), .WIN_LOG2(WIN_LOG2),
      .ALIAS_GAP(ALIAS_GAP), .WIN_BASE(WIN_BASE), .FETCH_FAULT(FETCH_FAULT),
      .POS_W(POS_W)
   ) u_dec (
      .addr_w(m_addr[ADDR_W-1:2]),
      .hit(hit),
      .fetch_fault(fetch_fault),
      .tgt_byte(tgt_byte),
      .bitpos(bitpos)
   );

   assign tgt_addr = {tgt_byte[ADDR_W-1:3], tgt_byte[2:0] & ~size_low_mask(m_size)};

   always_comb begin
      route = K_PASS;
      if (m_req && hit) begin
         if (m_excl || (m_fetch && fetch_fault)) route = K_FAULT;
         else if (!m_fetch)                       route = m_we ? K_ALIAS_WR : K_ALIAS_RD;
      end
   end

   bb_rmw_seq #(.DW(DW), .POS_W(POS_W)) u_rmw (
      .clk(clk),
      .rst_n(rst_n),
      .start(route == K_ALIAS_WR),
      .s_ready(s_ready),
      .s_rdata(s_rdata),
      .bitpos(bitpos),
      .new_bit(m_wdata[0]),
      .wr_phase(wr_phase),
      .merged(merged)
   );

   always_comb begin
      s_req   = m_req;
      s_addr  = m_addr;
      s_we    = m_we;
      s_size  = m_size;
      s_wdata = m_wdata;
      s_lock  = 1'b0;
      m_ready = s_ready;
      m_rdata = s_rdata;
      m_err   = 1'b0;
      unique case (route)
         K_ALIAS_RD: begin
            s_addr  = tgt_addr;
            s_we    = 1'b0;
            s_wdata = '0;
            m_rdata = {{(DW-1){1'b0}}, s_rdata[bitpos]};
         end
         K_ALIAS_WR: begin
            s_addr  = tgt_addr;
            s_lock  = 1'b1;
            s_we    = wr_phase;
            s_wdata = wr_phase ? merged : '0;
            m_ready = wr_phase && s_ready;
         end
         K_FAULT: begin
            s_req   = 1'b0;
            m_ready = 1'b1;
            m_rdata = '0;
            m_err   = 1'b1;
         end
         default: ;
      endcase
   end

   // R5: an accepted locked read is followed by the locked write to the same place
   p_write_follows_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (s_req && s_lock && !s_we && s_ready) |=>
         (s_req && s_lock && s_we && $stable(s_addr) && $stable(s_size)));

   // R6: the master is held off while the locked read is in flight
   p_hold_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (s_req && s_lock && !s_we) |-> !m_ready);

   // R8: an error response never coincides with a slave request
   p_fault_local_r8: assert property (@(posedge clk) disable iff (!rst_n)
      m_err |-> (m_ready && !s_req && m_rdata == '0));

   // R4: a completed alias read carries only bit 0
   p_read_isolated_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (m_req && hit && !m_we && !m_fetch && m_ready && !m_err) |-> (m_rdata[DW-1:1] == '0));

   // R1: the lock flag is raised only for remapped alias traffic
   p_lock_alias_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
      s_lock |-> (m_req && hit && s_req));

endmodule

// File: tb/bb_alias_unit_test.sv
`timescale 1ns/10ps
module bb_alias_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        m_req = 1'b0;
   logic [31:0] m_addr = '0;
   logic        m_we = 1'b0;
   logic [1:0]  m_size = 2'd2;
   logic [31:0] m_wdata = '0;
   logic        m_fetch = 1'b0;
   logic        m_excl = 1'b0;
   logic        m_ready;
   logic [31:0] m_rdata;
   logic        m_err;
   logic        s_req;
   logic [31:0] s_addr;
   logic        s_we;
   logic [1:0]  s_size;
   logic [31:0] s_wdata;
   logic        s_lock;
   logic        s_ready = 1'b1;
   logic [31:0] s_rdata = '0;

   always #2 clk = ~clk;

   bb_alias_unit uut (
      .clk(clk), .rst_n(rst_n),
      .m_req(m_req), .m_addr(m_addr), .m_we(m_we), .m_size(m_size),
      .m_wdata(m_wdata), .m_fetch(m_fetch), .m_excl(m_excl),
      .m_ready(m_ready), .m_rdata(m_rdata), .m_err(m_err),
      .s_req(s_req), .s_addr(s_addr), .s_we(s_we), .s_size(s_size),
      .s_wdata(s_wdata), .s_lock(s_lock), .s_ready(s_ready), .s_rdata(s_rdata)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // ---------------- memories: slave contents and reference contents
   logic [31:0] mem     [int unsigned];
   logic [31:0] ref_mem [int unsigned];

   function automatic logic [31:0] seed_of(input int unsigned wa);
      return (wa * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
   endfunction
   function automatic logic [31:0] mem_rd(input int unsigned wa);
      if (mem.exists(wa)) return mem[wa];
      return seed_of(wa);
   endfunction
   function automatic logic [31:0] ref_rd(input int unsigned wa);
      if (ref_mem.exists(wa)) return ref_mem[wa];
      return seed_of(wa);
   endfunction
   function automatic logic [31:0] lane_mask(input logic [31:0] a, input logic [1:0] sz);
      case (sz)
         2'd0:    return 32'h0000_00FF << (8 * int'(a[1:0]));
         2'd1:    return 32'h0000_FFFF << (16 * int'(a[1]));
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

   // ---------------- slave model and monitor
   int          cyc = 0;
   int          stall_mode = 0;
   int          slave_xfers = 0;
   logic [31:0] last_addr = '0;
   logic [1:0]  last_size = '0;
   bit          lock_pending = 0;
   logic [31:0] lock_addr = '0;

   always @(posedge clk) begin
      cyc++;
      if (rst_n && s_req && s_ready) begin
         slave_xfers++;
         last_addr = s_addr;
         last_size = s_size;
         if (lock_pending) begin
            chk(s_lock && s_we && s_addr == lock_addr, "R6",
                "transfer after locked read", s_addr, lock_addr);
            lock_pending = 0;
         end else if (s_lock) begin
            chk(!s_we, "R5", "locked pair starts with read", 32'(s_we), 32'd0);
            lock_pending = 1;
            lock_addr    = s_addr;
         end
         if (s_we) begin
            logic [31:0] m;
            m = lane_mask(s_addr, s_size);
            mem[int'(s_addr & ~32'h3)] = (mem_rd(int'(s_addr & ~32'h3)) & ~m) | (s_wdata & m);
         end
      end
      #0.5;
      case (stall_mode)
         0:       s_ready = 1'b1;
         1:       s_ready = (cyc % 3) != 0;
         default: s_ready = (cyc % 4) == 1;
      endcase
      #0.5;
      s_rdata = mem_rd(int'(s_addr & ~32'h3));
   end

   // ---------------- every-clock comparison against the expected response class
   bit    cur_active = 0;
   bit    cur_err    = 0;
   string cur_tag    = "R1";

   always @(negedge clk) begin
      if (rst_n && s_req && s_lock && !s_we)
         chk(!m_ready, "R6", "master ready during locked read", 32'(m_ready), 32'd0);
      if (rst_n && cur_active)
         chk(m_err == cur_err && (!cur_err || (m_ready && !s_req)), cur_tag,
             "per-cycle error/slave request", {30'd0, m_err, s_req}, {30'd0, cur_err, 1'b0});
   end

   // ---------------- reference model of one master transfer
   localparam logic [31:0] WB0 = 32'h2000_0000;
   localparam logic [31:0] WB1 = 32'h4000_0000;
   localparam logic [31:0] GAP = 32'h0200_0000;

   task automatic xfer(input logic [31:0] a, input logic we, input logic [1:0] sz,
                       input logic [31:0] wd, input logic fe, input logic ex);
      bit          hit = 0, exp_err = 0, alias_op = 0;
      int          wsel = 0;
      logic [31:0] off = '0, base = '0, byte_a, wa, exp_rd = '0, exp_sa = a, v;
      int          pos, sx0, waited = 0;
      string       tag;

      for (int w = 0; w < 2; w++) begin
         logic [31:0] bw, ab;
         bw = (w == 0) ? WB0 : WB1;
         ab = bw + GAP;
         if (a >= ab && (a - ab) < GAP) begin
            hit = 1; wsel = w; off = a - ab; base = bw;
         end
      end
      wa  = a & ~32'h3;
      tag = "R1";
      if (hit && (ex || (fe && wsel == 1))) begin
         exp_err = 1;
         tag = ex ? "R9" : "R8";
      end else if (hit && !fe) begin
         alias_op = 1;
         byte_a = base + (off >> 5);
         pos    = int'((off >> 2) & 32'h7) + 8 * int'(byte_a & 32'h3);
         wa     = byte_a & ~32'h3;
         exp_sa = byte_a & ~((sz == 2'd0) ? 32'h0 : (sz == 2'd1) ? 32'h1 : 32'h3);
         tag    = we ? "R5" : "R4";
         v = ref_rd(wa);
         if (we) begin
            v[pos] = wd[0];
            ref_mem[wa] = v;
         end else begin
            exp_rd = {31'd0, v[pos]};
         end
      end else begin
         if (hit) tag = "R7";
         if (we) ref_mem[wa] = (ref_rd(wa) & ~lane_mask(a, sz)) | (wd & lane_mask(a, sz));
         else    exp_rd = ref_rd(wa);
      end

      @(posedge clk);
      #0.5;
      sx0 = slave_xfers;
      m_req = 1'b1; m_addr = a; m_we = we; m_size = sz; m_wdata = wd;
      m_fetch = fe; m_excl = ex;
      cur_active = 1; cur_err = exp_err; cur_tag = tag;
      forever begin
         @(negedge clk);
         if (m_ready) break;
         waited++;
         if (waited > 40) break;
      end
      chk(waited <= 40, "R6", "master ready timeout", 32'(waited), 32'd40);
      chk(m_err == exp_err, tag, "error flag", 32'(m_err), 32'(exp_err));
      if (exp_err)
         chk(m_rdata == 32'd0, tag, "error read data", m_rdata, 32'd0);
      else if (!we)
         chk(m_rdata == exp_rd, tag, "read data", m_rdata, exp_rd);
      @(posedge clk);
      #0.5;
      cur_active = 0;
      m_req = 1'b0; m_we = 1'b0; m_fetch = 1'b0; m_excl = 1'b0;
      if (exp_err) begin
         chk(slave_xfers == sx0, tag, "slave transfers on error", 32'(slave_xfers - sx0), 32'd0);
      end else if (alias_op) begin
         chk(slave_xfers == sx0 + (we ? 2 : 1), "R5", "alias slave transfer count",
             32'(slave_xfers - sx0), we ? 32'd2 : 32'd1);
         chk(last_addr == exp_sa && last_size == sz, "R3", "remapped address/size",
             last_addr, exp_sa);
      end else begin
         chk(slave_xfers == sx0 + 1 && last_addr == a && last_size == sz, tag,
             "pass-through address", last_addr, a);
      end
      chk(mem_rd(wa) == ref_rd(wa), tag, "memory word", mem_rd(wa), ref_rd(wa));
   endtask

   // ---------------- watchdog
   initial begin
      #(4 * 150000);
      if (!done) begin
         chk(0, "R6", "watchdog expired", 32'(cyc), 32'd0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   // ---------------- stimulus
   initial begin
      repeat (3) @(posedge clk);
      #0.5 rst_n = 1'b1;
      @(negedge clk);
      // R10: idle after reset
      chk(!s_req && !s_lock && !m_err, "R10", "idle outputs after reset",
          {29'd0, s_req, s_lock, m_err}, 32'd0);

      for (int mode = 0; mode < 3; mode++) begin
         stall_mode = mode;
         // R1: direct window traffic and near-miss addresses
         xfer(32'h2000_0004, 1'b0, 2'd2, 32'h0, 1'b0, 1'b0);
         xfer(32'h2000_0005, 1'b1, 2'd0, 32'h0000_A500, 1'b0, 1'b0);
         xfer(32'h2000_0004, 1'b0, 2'd2, 32'h0, 1'b0, 1'b0);
         xfer(32'h4000_0010, 1'b0, 2'd2, 32'h0, 1'b0, 1'b0);
         // R2: just outside the SRAM alias on both sides
         xfer(32'h21FF_FFFC, 1'b0, 2'd2, 32'h0, 1'b0, 1'b0);
         xfer(32'h2400_0000, 1'b0, 2'd2, 32'h0, 1'b0, 1'b0);
         // R4/R5: set then clear byte 5 bit 3 through the SRAM alias (bus bit 11)
         xfer(32'h2200_00AC, 1'b1, 2'd2, 32'h1, 1'b0, 1'b0);
         xfer(32'h2200_00AC, 1'b0, 2'd2, 32'h0, 1'b0, 1'b0);
         xfer(32'h2000_0004, 1'b0, 2'd2, 32'h0, 1'b0, 1'b0);
         xfer(32'h2200_00AC, 1'b1, 2'd2, 32'hFFFF_FFFE, 1'b0, 1'b0);
         xfer(32'h2200_00AC, 1'b0, 2'd2, 32'h0, 1'b0, 1'b0);
         // R3: halfword and byte sized alias writes and reads
         xfer(32'h2200_00F8, 1'b1, 2'd1, 32'h1, 1'b0, 1'b0);
         xfer(32'h2200_00F8, 1'b0, 2'd1, 32'h0, 1'b0, 1'b0);
         xfer(32'h2200_00D0, 1'b1, 2'd0, 32'h0, 1'b0, 1'b0);
         xfer(32'h2200_00D0, 1'b0, 2'd0, 32'h0, 1'b0, 1'b0);
         // R2: peripheral alias, first and last words of the SRAM alias
         xfer(32'h4200_0044, 1'b1, 2'd2, 32'h1, 1'b0, 1'b0);
         xfer(32'h4200_0044, 1'b0, 2'd2, 32'h0, 1'b0, 1'b0);
         xfer(32'h2200_0000, 1'b0, 2'd2, 32'h0, 1'b0, 1'b0);
         xfer(32'h23FF_FFFC, 1'b1, 2'd2, 32'h1, 1'b0, 1'b0);
         xfer(32'h23FF_FFFC, 1'b0, 2'd2, 32'h0, 1'b0, 1'b0);
         xfer(32'h23FF_FFFC, 1'b1, 2'd2, 32'h0, 1'b0, 1'b0);
         xfer(32'h23FF_FFFC, 1'b0, 2'd2, 32'h0, 1'b0, 1'b0);
         // R7: SRAM alias fetch passes through unremapped
         xfer(32'h2200_0040, 1'b0, 2'd2, 32'h0, 1'b1, 1'b0);
         // R8: peripheral alias fetch faults
         xfer(32'h4200_0040, 1'b0, 2'd2, 32'h0, 1'b1, 1'b0);
         // R9: exclusive to either alias faults, outside passes
         xfer(32'h2200_0040, 1'b1, 2'd2, 32'h1, 1'b0, 1'b1);
         xfer(32'h4300_0000, 1'b0, 2'd2, 32'h0, 1'b0, 1'b1);
         xfer(32'h2000_0008, 1'b0, 2'd2, 32'h0, 1'b0, 1'b1);
      end

      // mixed traffic over a small footprint so bits are revisited
      for (int i = 0; i < 300; i++) begin
         logic [31:0] a, wd, bw;
         logic [1:0]  sz;
         logic        fe, ex, we;
         stall_mode = i % 3;
         bw = ($urandom_range(0, 1) == 0) ? WB0 : WB1;
         sz = 2'($urandom_range(0, 2));
         wd = $urandom;
         fe = ($urandom_range(0, 9) == 0);
         ex = ($urandom_range(0, 11) == 0);
         we = fe ? 1'b0 : 1'($urandom_range(0, 1));
         if ($urandom_range(0, 2) != 0)
            a = bw + GAP + 32'($urandom_range(0, 511)) * 4;
         else
            a = (bw + 32'($urandom_range(0, 15))) &
                ~((sz == 2'd0) ? 32'h0 : (sz == 2'd1) ? 32'h1 : 32'h3);
         xfer(a, we, sz, wd, fe, ex);
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule